// File: doc/BRIEF.md
# Programmable Preamble Generator

This block produces the serial preamble that opens every transmit burst. A preamble is a sync word sent a configurable number of times, followed by a single frame delimiter. The sync word pattern, its length, the repeat count, the delimiter pattern and the delimiter length are all static configuration inputs. Lengths are given as compact codes: a code of n selects n+1 bits.

A transmit burst is requested by pulling the active-low request line low. The block then shifts the preamble out one bit per bit-clock enable and holds `busy` high while it does so. After the last delimiter bit it raises a one-cycle `preamble_done` strobe, which hands the burst over to the user-data path. Preamble bits go straight to the serial output. They are not bit-stuffed and are not covered by any CRC, so the block contains no such logic.

If the request line is released part-way through, the block drops the preamble at once. It then returns to idle with its output low.

Top module: `preamble_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `ser_out` and `preamble_done` are all 0.
- R2: In idle, a 1-to-0 change of `tx_start_n` (sampled on consecutive clock edges) starts a preamble, and `busy` is 1 from the next cycle. Holding `tx_start_n` low after a preamble ends does not start another one.
- R3: The sync field uses the low L = code+1 bits of `sync_pattern` (code in `sync_len_code`). Bit L-1 goes out first and bit 0 last. Each bit stays on `ser_out` until a cycle with `bit_en` = 1 consumes it.
- R4: The sync field is sent `sync_count` times back to back, and the delimiter follows immediately.
- R5: The delimiter uses the low L = code+1 bits of `delim_pattern` (code in `delim_len_code`), sent from bit L-1 down to bit 0. It is paced the same way as the sync field.
- R6: A length code of 0 counts as a 1-bit field, and that field carries bit 0 of its pattern.
- R7: A `sync_count` of 0 skips the sync field, so only the delimiter is sent.
- R8: `preamble_done` is 1 for exactly one cycle: the cycle after the `bit_en` cycle that consumed the last delimiter bit. In that same cycle `busy` is already 0.
- R9: If `tx_start_n` is 1 at a clock edge while `busy` is 1, the block is idle from the next cycle, with `ser_out` = 0 and no `preamble_done`.
- R10: Whenever `busy` is 0, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_start_n | input | 1 | Transmit request, active low; its falling edge starts a preamble |
| bit_en | input | 1 | Bit-clock enable; each high cycle consumes one preamble bit |
| sync_pattern | input | SYNC_W (8) | Sync word pattern |
| sync_len_code | input | SYNC_SEL_W (3) | Sync word length code, length = code+1 |
| sync_count | input | COUNT_W (8) | Number of sync words per preamble |
| delim_pattern | input | DELIM_W (32) | Frame delimiter pattern |
| delim_len_code | input | DELIM_SEL_W (5) | Delimiter length code, length = code+1 |
| ser_out | output | 1 | Serial preamble bit |
| busy | output | 1 | Preamble in progress |
| preamble_done | output | 1 | One-cycle strobe after the last delimiter bit |

## Verification
The embedded assertions check, on every cycle:
- the completion strobe lasts one cycle and coincides with `busy` falling;
- withdrawing the request empties the block in one cycle;
- the output bit holds while no enable arrives;
- a request edge in idle makes the block busy;
- neither down-counter ever steps below zero.

Only the bench's scenarios can show that the right bits come out in the right order. Those scenarios cover:
- MSB-first field ordering;
- the number of sync repetitions;
- the one-bit meaning of code 0;
- skipping the sync field when the count is 0.

The bench also checks that a held-low request does not retrigger, and that sparse enables stretch each bit correctly.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_SYNC  = 2'd1,
        PG_DELIM = 2'd2
    } pg_state_e;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pg_start_detect.sv
module pg_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    output logic start_evt,
    output logic withdraw
);
    logic req_n_q;

    always_ff @(posedge clk) begin
        if (rst) req_n_q <= 1'b1;
        else     req_n_q <= req_n;
    end

    assign start_evt = req_n_q & ~req_n;
    assign withdraw  = req_n;
endmodule

// File: rtl/pg_down_count.sv
module pg_down_count #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_zero
);
    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (step) value <= value - 1'b1;
    end

    assign at_zero = (value == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |-> !at_zero);  // R4
endmodule

// File: rtl/pg_bit_pick.sv
module pg_bit_pick #(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic [W-1:0]     pattern,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    assign bit_o = pattern[sel];
endmodule

// File: rtl/preamble_gen.sv
module preamble_gen
    import pg_pkg::*;
#(
    parameter int SYNC_W      = 8,
    parameter int DELIM_W     = 32,
    parameter int COUNT_W     = 8,
    parameter int SYNC_SEL_W  = $clog2(SYNC_W),
    parameter int DELIM_SEL_W = $clog2(DELIM_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tx_start_n,
    input  logic                   bit_en,
    input  logic [SYNC_W-1:0]      sync_pattern,
    input  logic [SYNC_SEL_W-1:0]  sync_len_code,
    input  logic [COUNT_W-1:0]     sync_count,
    input  logic [DELIM_W-1:0]     delim_pattern,
    input  logic [DELIM_SEL_W-1:0] delim_len_code,
    output logic                   ser_out,
    output logic                   busy,
    output logic                   preamble_done
);
    localparam int IDX_W = max_i(SYNC_SEL_W, DELIM_SEL_W);

    pg_state_e          st, st_n;
    logic               start_evt, withdraw;
    logic               idx_load, idx_step, idx_zero;
    logic [IDX_W-1:0]   idx_val, idx;
    logic               rep_load, rep_step, rep_zero;
    logic [COUNT_W-1:0] rep_left;
    logic               done_n;
    logic               sync_bit, delim_bit;
    logic [IDX_W-1:0]   sync_top, delim_top;

    // The top index of a field with code n is n: a code n >= 1 means n+1 bits,
    // and code 0 means a single bit at index 0.
    assign sync_top  = IDX_W'(sync_len_code);
    assign delim_top = IDX_W'(delim_len_code);

    pg_start_detect u_start (
        .clk(clk), .rst(rst), .req_n(tx_start_n),
        .start_evt(start_evt), .withdraw(withdraw)
    );

    pg_down_count #(.W(IDX_W)) u_bit_idx (
        .clk(clk), .rst(rst), .load(idx_load), .load_val(idx_val),
        .step(idx_step), .value(idx), .at_zero(idx_zero)
    );

    pg_down_count #(.W(COUNT_W)) u_rep (
        .clk(clk), .rst(rst), .load(rep_load), .load_val(sync_count),
        .step(rep_step), .value(rep_left), .at_zero(rep_zero)
    );

    pg_bit_pick #(.W(SYNC_W)) u_sync_pick (
        .pattern(sync_pattern), .sel(idx[SYNC_SEL_W-1:0]), .bit_o(sync_bit)
    );

    pg_bit_pick #(.W(DELIM_W)) u_delim_pick (
        .pattern(delim_pattern), .sel(idx[DELIM_SEL_W-1:0]), .bit_o(delim_bit)
    );

    always_comb begin
        st_n     = st;
        idx_load = 1'b0;
        idx_val  = '0;
        idx_step = 1'b0;
        rep_load = 1'b0;
        rep_step = 1'b0;
        done_n   = 1'b0;
        unique case (st)
            PG_IDLE: begin
                if (start_evt) begin
                    idx_load = 1'b1;
                    if (sync_count != '0) begin
                        st_n     = PG_SYNC;
                        idx_val  = sync_top;
                        rep_load = 1'b1;
                    end else begin
                        st_n    = PG_DELIM;
                        idx_val = delim_top;
                    end
                end
            end
            PG_SYNC: begin
                if (withdraw) begin
                    st_n = PG_IDLE;
                end else if (bit_en) begin
                    if (!idx_zero) begin
                        idx_step = 1'b1;
                    end else if (rep_left == COUNT_W'(1)) begin
                        st_n     = PG_DELIM;
                        idx_load = 1'b1;
                        idx_val  = delim_top;
                    end else begin
                        rep_step = 1'b1;
                        idx_load = 1'b1;
                        idx_val  = sync_top;
                    end
                end
            end
            PG_DELIM: begin
                if (withdraw) begin
                    st_n = PG_IDLE;
                end else if (bit_en) begin
                    if (!idx_zero) begin
                        idx_step = 1'b1;
                    end else begin
                        st_n   = PG_IDLE;
                        done_n = 1'b1;
                    end
                end
            end
            default: st_n = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= PG_IDLE;
            preamble_done <= 1'b0;
        end else begin
            st            <= st_n;
            preamble_done <= done_n;
        end
    end

    always_comb begin
        unique case (st)
            PG_SYNC:  ser_out = sync_bit;
            PG_DELIM: ser_out = delim_bit;
            default:  ser_out = 1'b0;
        endcase
    end

    assign busy = (st != PG_IDLE);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        preamble_done |=> !preamble_done);  // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        preamble_done |-> (!busy && $past(busy)));  // R8
    AST_WITHDRAW_IDLE: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_start_n) |=> (!busy && !preamble_done && !ser_out));  // R9
    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_en && !tx_start_n) |=> (busy && $stable(ser_out)));  // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_evt) |=> busy);  // R2
    AST_REP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (st == PG_SYNC) |-> !rep_zero);  // R7
endmodule

// File: tb/sim_preamble_gen.sv
module sim_preamble_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_start_n = 1'b1;
    logic        bit_en = 1'b0;
    logic [7:0]  sync_pattern = '0;
    logic [2:0]  sync_len_code = '0;
    logic [7:0]  sync_count = '0;
    logic [31:0] delim_pattern = '0;
    logic [4:0]  delim_len_code = '0;
    logic        ser_out, busy, preamble_done;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    int    en_div = 1;
    int    en_cnt = 0;
    string cur_req = "R3";

    // behavioural reference state
    bit    m_q[$];
    bit    m_active = 1'b0;
    bit    m_done = 1'b0;
    bit    m_prev_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    preamble_gen u0 (
        .clk(clk), .rst(rst), .tx_start_n(tx_start_n), .bit_en(bit_en),
        .sync_pattern(sync_pattern), .sync_len_code(sync_len_code),
        .sync_count(sync_count), .delim_pattern(delim_pattern),
        .delim_len_code(delim_len_code), .ser_out(ser_out), .busy(busy),
        .preamble_done(preamble_done)
    );

    function automatic void build_queue();
        int sl = (sync_len_code == 0) ? 1 : int'(sync_len_code) + 1;
        int dl = (delim_len_code == 0) ? 1 : int'(delim_len_code) + 1;
        m_q.delete();
        for (int w = 0; w < int'(sync_count); w++)
            for (int i = sl - 1; i >= 0; i--) m_q.push_back(sync_pattern[i]);
        for (int i = dl - 1; i >= 0; i--) m_q.push_back(delim_pattern[i]);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_active = 0; m_done = 0; m_prev_n = 1; m_q.delete();
        end else begin
            m_done = 0;
            if (m_active) begin
                if (tx_start_n) begin
                    m_active = 0; m_q.delete();
                end else if (bit_en) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) begin m_active = 0; m_done = 1; end
                end
            end else if (m_prev_n && !tx_start_n) begin
                build_queue();
                m_active = 1;
            end
            m_prev_n = tx_start_n;
        end
    end

    task automatic check1(input string req, input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cycles, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic e_ser;
            e_ser = m_active ? m_q[0] : 1'b0;
            check1("R2", "busy", busy, m_active);
            check1("R8", "preamble_done", preamble_done, m_done);
            check1(m_active ? cur_req : "R10", "ser_out", ser_out, e_ser);
        end
        en_cnt++;
        bit_en = (en_div <= 1) ? 1'b1 : ((en_cnt % en_div) == 0);
    end

    task automatic run(input logic [7:0] sp, input logic [2:0] sc, input logic [7:0] cnt,
                       input logic [31:0] dp, input logic [4:0] dc, input int div,
                       input string req);
        @(negedge clk);
        sync_pattern = sp; sync_len_code = sc; sync_count = cnt;
        delim_pattern = dp; delim_len_code = dc; en_div = div; cur_req = req;
        @(negedge clk);
        tx_start_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 20000 && m_active; k++) @(negedge clk);
        // hold the request low: no second preamble may start (R2)
        repeat (6) @(negedge clk);
        check1("R2", "no restart while held low", busy, 1'b0);
        tx_start_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check1("R1", "busy in reset", busy, 1'b0);
        check1("R1", "ser_out in reset", ser_out, 1'b0);
        check1("R1", "done in reset", preamble_done, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check1("R1", "busy after reset", busy, 1'b0);

        run(8'hA5, 3'd7, 8'd3, 32'h0000_F00D, 5'd15, 1, "R3");
        run(8'b0000_0110, 3'd2, 8'd1, 32'hC3A5_0F96, 5'd31, 3, "R5");
        run(8'hFF, 3'd4, 8'd0, 32'h0000_002D, 5'd5, 2, "R7");
        run(8'h01, 3'd0, 8'd2, 32'hFFFF_FFFE, 5'd0, 1, "R6");
        run(8'h02, 3'd1, 8'd255, 32'h0000_0005, 5'd2, 1, "R4");

        // withdrawal part-way through the sync field
        @(negedge clk);
        sync_pattern = 8'hF0; sync_len_code = 3'd7; sync_count = 8'd4;
        delim_pattern = 32'h1; delim_len_code = 5'd3; en_div = 1; cur_req = "R9";
        @(negedge clk);
        tx_start_n = 1'b0;
        repeat (7) @(negedge clk);
        tx_start_n = 1'b1;
        @(negedge clk);
        check1("R9", "busy after withdraw", busy, 1'b0);
        check1("R9", "ser_out after withdraw", ser_out, 1'b0);
        check1("R9", "done after withdraw", preamble_done, 1'b0);
        repeat (4) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule